// File: doc/BRIEF.md
# Fractional-N Synthesizer Divider Chain

This block holds the digital counters of a frequency synthesizer loop. A reference counter turns the reference clock into a compare pulse once every R+1 reference cycles. A feedback counter runs on the output clock of an external 4/5 dual-modulus prescaler. It issues one feedback pulse per output period and drives the modulus-control line that picks divide-by-5 or divide-by-4 for each prescaler cycle.

The feedback counter uses the pulse-swallow scheme. For a total ratio D, a period lasts D/4 (rounded down) prescaler-output cycles. The first D mod 4 of those cycles run at modulus 5, so the VCO sees 4·(D div 4) + (D mod 4) = D cycles per feedback pulse. A fractional accumulator adds the programmed fractional word once per feedback period, and that period divides by N+1 whenever the addition carries out. The average ratio is then N + frac/2^F_W. In lock, one feedback period spans exactly one compare period, so the accumulator advances once per compare period without crossing clock domains.

The divide settings are sampled only at terminal count, so every period comes out whole. The analog loop, the phase detector and the prescaler itself lie outside this block. The pulse-swallow arithmetic is exact for ratios of 12 and above. Below 12, a period is never shorter than one cycle and the modulus-5 run is cut short at the period's end.

Top module: `fracn_divider`

## Requirements
- R1: `refPulse` is high for exactly one `refClk` cycle in every run of R'+1 cycles, where R' is the effective R setting; with R'=0 it is high on every cycle.
- R2: `cfgR` values above 128 act as 128.
- R3: For a ratio D, one feedback period lasts max(D>>2, 1) `fbClk` cycles, and `fbPulse` is high only in the last cycle of each period.
- R4: `modCtl` is high (1 = modulus 5, 0 = modulus 4) in the first (D mod 4) cycles of each feedback period, limited to the period length, and is low in the rest.
- R5: An F_W-bit accumulator adds `cfgFrac` at the start of every feedback period. That period uses D = N'+1 when the sum carries out of F_W bits and D = N' otherwise, where N' is the effective N setting.
- R6: `cfgN` is clamped to the range 3 to 1022 before use.
- R7: `cfgR` is read only when a reference period starts, and `cfgN` and `cfgFrac` only when a feedback period starts. A change part-way through a period does not alter that period.
- R8: While `rstN` is low, all outputs are low and the counters and accumulator are cleared. The first edge of each clock after reset starts a period with the settings present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock |
| fbClk | input | 1 | Prescaler output clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgR | input | 8 | Reference divide setting R (ratio R+1) |
| cfgN | input | 10 | Integer feedback ratio N |
| cfgFrac | input | 8 | Fractional word |
| refPulse | output | 1 | Compare pulse, refClk domain |
| fbPulse | output | 1 | Feedback pulse, fbClk domain |
| modCtl | output | 1 | Prescaler modulus select, 1 = divide by 5 |

## Verification
The bench builds the block with its default widths: an 8-bit R field, a 10-bit N field and an 8-bit fractional word. With these widths the bench can drive R and N values past both clamp limits, including N below 3, where every cycle is a terminal count with modulus 5. They also let a 256-period run pass through a full accumulator cycle, so the number of carries can be counted exactly against the fractional word.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  // prescaler low modulus is 2**MOD_LOG2 = 4
  localparam int MOD_LOG2 = 2;

  typedef struct packed {
    logic load;   // feedback period ends this cycle: take new ratio
  } fbStrobe_t;
endpackage

// File: rtl/fracn_ref_div.sv
module fracn_ref_div #(
  parameter int R_W   = 8,
  parameter int R_MAX = 128
) (
  input  logic           refClk,
  input  logic           rstN,
  input  logic [R_W-1:0] cfgR,
  output logic           refPulse
);
  logic [R_W-1:0] rCnt, rLast, rClamp, nxtCnt, nxtLast;
  logic           rTc;

  always_comb begin
    rClamp  = (cfgR > R_W'(R_MAX)) ? R_W'(R_MAX) : cfgR;
    rTc     = (rCnt == rLast);
    nxtCnt  = rTc ? '0 : rCnt + 1'b1;
    nxtLast = rTc ? rClamp : rLast;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      rCnt     <= '0;
      rLast    <= '0;
      refPulse <= 1'b0;
    end else begin
      rCnt     <= nxtCnt;
      rLast    <= nxtLast;
      refPulse <= (nxtCnt == nxtLast);
    end
  end
endmodule

// File: rtl/fracn_fb_dp.sv
module fracn_fb_dp
  import fracn_pkg::*;
#(
  parameter int N_W   = 10,
  parameter int N_MIN = 3,
  parameter int N_MAX = 1022,
  parameter int F_W   = 8,
  localparam int D_W   = N_W + 1,
  localparam int CNT_W = D_W - MOD_LOG2
) (
  input  logic             fbClk,
  input  logic             rstN,
  input  logic [N_W-1:0]   cfgN,
  input  logic [F_W-1:0]   cfgFrac,
  input  fbStrobe_t        strobe,
  output logic [CNT_W-1:0] curLast,
  output logic [1:0]       curSwal,
  output logic [CNT_W-1:0] newLast,
  output logic [1:0]       newSwal
);
  logic [F_W-1:0]   acc;
  logic [F_W:0]     sum;
  logic [N_W-1:0]   nClamp;
  logic [D_W-1:0]   ratio;
  logic [CNT_W-1:0] mainCnt;

  always_comb begin
    sum = {1'b0, acc} + {1'b0, cfgFrac};
    if (cfgN < N_W'(N_MIN))      nClamp = N_W'(N_MIN);
    else if (cfgN > N_W'(N_MAX)) nClamp = N_W'(N_MAX);
    else                         nClamp = cfgN;
    ratio   = {1'b0, nClamp} + D_W'(sum[F_W]);
    mainCnt = ratio[D_W-1:MOD_LOG2];
    newLast = (mainCnt == '0) ? '0 : mainCnt - 1'b1;
    newSwal = ratio[MOD_LOG2-1:0];
  end

  always_ff @(posedge fbClk or negedge rstN) begin
    if (!rstN) begin
      acc     <= '0;
      curLast <= '0;
      curSwal <= '0;
    end else if (strobe.load) begin
      acc     <= sum[F_W-1:0];
      curLast <= newLast;
      curSwal <= newSwal;
    end
  end
endmodule

// File: rtl/fracn_fb_ctrl.sv
module fracn_fb_ctrl
  import fracn_pkg::*;
#(
  parameter int N_W = 10,
  localparam int CNT_W = N_W + 1 - MOD_LOG2
) (
  input  logic             fbClk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] curLast,
  input  logic [1:0]       curSwal,
  input  logic [CNT_W-1:0] newLast,
  input  logic [1:0]       newSwal,
  output fbStrobe_t        strobe,
  output logic             fbPulse,
  output logic             modCtl
);
  logic [CNT_W-1:0] cnt, nxtCnt, nxtLast;
  logic [1:0]       nxtSwal;

  always_comb begin
    strobe.load = (cnt == curLast);
    nxtCnt      = strobe.load ? '0 : cnt + 1'b1;
    nxtLast     = strobe.load ? newLast : curLast;
    nxtSwal     = strobe.load ? newSwal : curSwal;
  end

  always_ff @(posedge fbClk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      fbPulse <= 1'b0;
      modCtl  <= 1'b0;
    end else begin
      cnt     <= nxtCnt;
      fbPulse <= (nxtCnt == nxtLast);
      modCtl  <= (nxtCnt < CNT_W'(nxtSwal));
    end
  end
endmodule

// File: rtl/fracn_divider.sv
module fracn_divider
  import fracn_pkg::*;
#(
  parameter int R_W   = 8,
  parameter int R_MAX = 128,
  parameter int N_W   = 10,
  parameter int N_MIN = 3,
  parameter int N_MAX = 1022,
  parameter int F_W   = 8
) (
  input  logic           refClk,
  input  logic           fbClk,
  input  logic           rstN,
  input  logic [R_W-1:0] cfgR,
  input  logic [N_W-1:0] cfgN,
  input  logic [F_W-1:0] cfgFrac,
  output logic           refPulse,
  output logic           fbPulse,
  output logic           modCtl
);
  localparam int CNT_W = N_W + 1 - MOD_LOG2;

  fbStrobe_t        strobe;
  logic [CNT_W-1:0] curLast, newLast;
  logic [1:0]       curSwal, newSwal;

  fracn_ref_div #(.R_W(R_W), .R_MAX(R_MAX)) u_refDiv (
    .refClk(refClk), .rstN(rstN), .cfgR(cfgR), .refPulse(refPulse)
  );

  fracn_fb_dp #(.N_W(N_W), .N_MIN(N_MIN), .N_MAX(N_MAX), .F_W(F_W)) u_fbDp (
    .fbClk(fbClk), .rstN(rstN), .cfgN(cfgN), .cfgFrac(cfgFrac),
    .strobe(strobe), .curLast(curLast), .curSwal(curSwal),
    .newLast(newLast), .newSwal(newSwal)
  );

  fracn_fb_ctrl #(.N_W(N_W)) u_fbCtrl (
    .fbClk(fbClk), .rstN(rstN), .curLast(curLast), .curSwal(curSwal),
    .newLast(newLast), .newSwal(newSwal), .strobe(strobe),
    .fbPulse(fbPulse), .modCtl(modCtl)
  );
endmodule

// File: rtl/fracn_divider_checker.sv
module fracn_divider_checker #(
  parameter int R_MAX = 128,
  parameter int N_MAX = 1022
) (
  input logic refClk,
  input logic fbClk,
  input logic rstN,
  input logic refPulse,
  input logic fbPulse,
  input logic modCtl
);
  localparam int FB_MAX = (N_MAX + 1) >> 2;

  logic [15:0] refGap, fbGap;
  logic [3:0]  hiRun;
  logic        seen1, seen2;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) refGap <= '0;
    else       refGap <= refPulse ? 16'd0 : refGap + 16'd1;
  end

  always_ff @(posedge fbClk or negedge rstN) begin
    if (!rstN) begin
      fbGap <= '0;
      hiRun <= '0;
      seen1 <= 1'b0;
      seen2 <= 1'b0;
    end else begin
      fbGap <= fbPulse ? 16'd0 : fbGap + 16'd1;
      hiRun <= fbPulse ? 4'd0 : hiRun + {3'd0, modCtl};
      seen1 <= 1'b1;
      seen2 <= seen1;
    end
  end

  // R8: outputs quiet while held in reset
  always @(posedge fbClk) begin
    if (!rstN) assert_reset_quiet_R8: assert (!fbPulse && !modCtl);
  end
  always @(posedge refClk) begin
    if (!rstN) assert_ref_reset_quiet_R8: assert (!refPulse);
  end

  // R1/R2: compare pulse never further apart than the clamped ratio
  assert_ref_gap_R2: assert property (@(posedge refClk) disable iff (!rstN)
    refGap <= 16'(R_MAX + 1));

  // R3/R6: feedback period bounded by the largest clamped ratio
  assert_fb_gap_R6: assert property (@(posedge fbClk) disable iff (!rstN)
    fbGap <= 16'(FB_MAX));

  // R4: modulus 5 only begins at a period start
  assert_mod_rise_R4: assert property (@(posedge fbClk) disable iff (!rstN)
    (seen2 && $rose(modCtl)) |-> $past(fbPulse));

  // R4: once back at modulus 4, it stays there until the period ends
  assert_mod_prefix_R4: assert property (@(posedge fbClk) disable iff (!rstN)
    (seen1 && !modCtl && !fbPulse) |=> !modCtl);

  // R4: at most three swallow cycles per period
  assert_swallow_limit_R4: assert property (@(posedge fbClk) disable iff (!rstN)
    hiRun <= 4'd3);
endmodule

bind fracn_divider fracn_divider_checker #(.R_MAX(R_MAX), .N_MAX(N_MAX)) u_chk (
  .refClk(refClk), .fbClk(fbClk), .rstN(rstN),
  .refPulse(refPulse), .fbPulse(fbPulse), .modCtl(modCtl)
);

// File: tb/fracn_divider_bench.sv
`timescale 1ns/1ps
module fracn_divider_bench;
  localparam int FRAC_MOD = 256;

  logic       refClk = 1'b0, fbClk = 1'b0, rstN = 1'b0;
  logic [7:0] cfgR = 8'd3;
  logic [9:0] cfgN = 10'd12;
  logic [7:0] cfgFrac = 8'd0;
  logic       refPulse, fbPulse, modCtl;

  int nChecks = 0, nFail = 0;
  int refQ[$];
  int fbQ[$];
  int expRef = 0, expFb = 0, acc = 0;
  bit refLive = 0, fbLive = 0, done = 0;

  always #10 refClk = ~refClk;   // 50 MHz
  always #8  fbClk  = ~fbClk;

  fracn_divider u_fracn_divider (
    .refClk(refClk), .fbClk(fbClk), .rstN(rstN), .cfgR(cfgR), .cfgN(cfgN),
    .cfgFrac(cfgFrac), .refPulse(refPulse), .fbPulse(fbPulse), .modCtl(modCtl)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: compare path
  always @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      refQ.delete(); refLive = 0;
    end else begin
      if (refQ.size() == 0) begin
        int rr;
        rr = (cfgR > 128) ? 128 : int'(cfgR);
        for (int k = 0; k < rr; k++) refQ.push_back(0);
        refQ.push_back(1);
      end
      expRef = refQ.pop_front();
      refLive = 1;
    end
  end

  // reference model: feedback path
  always @(posedge fbClk or negedge rstN) begin
    if (!rstN) begin
      fbQ.delete(); acc = 0; fbLive = 0;
    end else begin
      if (fbQ.size() == 0) begin
        int n, sum, d, p, s;
        n = int'(cfgN);
        if (n < 3) n = 3;
        if (n > 1022) n = 1022;
        sum = acc + int'(cfgFrac);
        d = n + ((sum >= FRAC_MOD) ? 1 : 0);
        acc = sum % FRAC_MOD;
        p = d / 4;
        if (p < 1) p = 1;
        s = d % 4;
        for (int k = 0; k < p; k++)
          fbQ.push_back(((k < s) ? 2 : 0) + ((k == p - 1) ? 1 : 0));
      end
      expFb = fbQ.pop_front();
      fbLive = 1;
    end
  end

  always @(negedge refClk) begin
    if (rstN && refLive && !done)
      check(refPulse == expRef[0], "R1/R2/R7 refPulse", int'(refPulse), expRef % 2);
  end

  always @(negedge fbClk) begin
    if (rstN && fbLive && !done) begin
      check(fbPulse == expFb[0], "R3/R5/R6/R7 fbPulse", int'(fbPulse), expFb % 2);
      check(modCtl == expFb[1], "R4/R5 modCtl", int'(modCtl), expFb / 2);
    end
  end

  task automatic finish();
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #4000000;
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    int cnt, hi, pulses;
    // R8: reset state
    repeat (3) @(negedge fbClk);
    check(!fbPulse && !modCtl, "R8 reset fb outputs", int'({fbPulse, modCtl}), 0);
    check(!refPulse, "R8 reset refPulse", int'(refPulse), 0);
    @(negedge fbClk); #3 rstN = 1'b1;

    // integer ratio 12, R=3
    repeat (200) @(negedge fbClk);

    // R1: R=0 pulses every reference cycle; N=37 -> swallow 1
    @(negedge refClk); cfgR = 8'd0;
    @(negedge fbClk);  cfgN = 10'd37;
    repeat (20) @(negedge refClk);
    for (int i = 0; i < 4; i++) begin
      @(negedge refClk);
      check(refPulse == 1'b1, "R1 R=0 pass-through", int'(refPulse), 1);
    end
    repeat (300) @(negedge fbClk);

    // R2/R6: clamps at the top
    @(negedge refClk); cfgR = 8'd200;
    @(negedge fbClk);  cfgN = 10'd1023;
    repeat (2000) @(negedge fbClk);
    // R2: measure one full compare period
    do @(negedge refClk); while (!refPulse);
    cnt = 0;
    do begin @(negedge refClk); cnt++; end while (!refPulse);
    check(cnt == 129, "R2 clamped R period", cnt, 129);

    // R6: N below 3 -> one-cycle periods, all at modulus 5
    @(negedge fbClk); cfgN = 10'd1;
    repeat (300) @(negedge fbClk);
    for (int i = 0; i < 3; i++) begin
      @(negedge fbClk);
      check(fbPulse && modCtl, "R6 clamped low N", int'({fbPulse, modCtl}), 3);
    end

    // R8: reset mid-run, then R5 carry count over a full accumulator cycle
    @(negedge fbClk); rstN = 1'b0; cfgN = 10'd100; cfgFrac = 8'd64;
    @(negedge fbClk);
    check(!fbPulse && !modCtl, "R8 mid-run reset", int'({fbPulse, modCtl}), 0);
    @(negedge refClk);
    check(!refPulse, "R8 mid-run reset ref", int'(refPulse), 0);
    @(negedge fbClk); #3 rstN = 1'b1;
    hi = 0; pulses = 0;
    repeat (6400) begin
      @(negedge fbClk);
      if (modCtl) hi++;
      if (fbPulse) pulses++;
    end
    check(hi == 64, "R5 swallow cycles in 256 periods", hi, 64);
    check(pulses == 256, "R3 pulses in 6400 cycles", pulses, 256);

    // R7: change N in mid-period
    cfgFrac = 8'd0; cfgN = 10'd400;
    repeat (300) @(negedge fbClk);
    do @(negedge fbClk); while (!fbPulse);
    repeat (30) @(negedge fbClk);
    cfgN = 10'd40;
    cnt = 30;
    do begin @(negedge fbClk); cnt++; end while (!fbPulse);
    check(cnt == 100, "R7 running period kept", cnt, 100);
    cnt = 0;
    do begin @(negedge fbClk); cnt++; end while (!fbPulse);
    check(cnt == 10, "R3/R7 new period length", cnt, 10);

    // R4: N=43 -> 10 cycles, first 3 at modulus 5
    cfgN = 10'd43;
    repeat (40) @(negedge fbClk);
    do @(negedge fbClk); while (!fbPulse);
    hi = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge fbClk);
      if (modCtl) hi++;
    end
    check(hi == 3, "R4 swallow count per period", hi, 3);
    repeat (50) @(negedge fbClk);
    finish();
  end
endmodule